// File: doc/BRIEF.md
# Resizable Reorder Buffer

This block is the in-order bookkeeping ring of an out-of-order core. Up to four entries are reserved at dispatch, and each reservation is granted whole or refused. Entries are marked complete out of order. They retire in program order, up to four per cycle, for as long as the oldest entry is complete. A branch-recovery flush names the youngest entry to keep and discards everything younger than it.

The capacity can be cut from 96 entries to 48 so that the upper half of the storage can be switched off while a long cache miss is being serviced. Raising the downsize input does not shrink the buffer at once. The buffer first drains any live entries out of the upper half, and until the change takes effect it refuses any reservation that would land there. Going back to full size waits until the live region no longer wraps around the 48-entry ring. Only then is it safe to make the wrap point 96 again.

Top module: `rob_resizable`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `empty`=1, `full`=0, `count`=0, `half_active`=0, `alloc_base`=0 and `commit_cnt`=0.
- R2: A request for 1 to 4 entries is accepted as a whole (`alloc_ok`=1) only when the free space is at least the request. The granted indices run consecutively from `alloc_base`, and `count` rises by the request one edge later. A refused request leaves `count` and `alloc_base` unchanged.
- R3: In each cycle, `commit_cnt` reports how many complete entries lie in an unbroken run starting at `commit_base`, capped at 4. The indices retired are `commit_base`+0..`commit_cnt`-1 modulo the active capacity. An incomplete entry at the head blocks every younger complete entry.
- R4: A completion presented in a cycle can be retired no earlier than the following cycle. A freshly granted entry always starts incomplete.
- R5: In a cycle with `flush_vld`=1, nothing is granted and nothing retires. On the next edge, `count` becomes the distance from the head to `flush_idx` plus one, and `alloc_base` becomes `flush_idx`+1 (wrapped).
- R6: `full` is 1 exactly when `count` equals the capacity in effect: 96 in full mode, 48 in half mode.
- R7: With `downsize`=1 in full mode, `half_active` stays 0 while any live entry has an index of 48 or above. During this wait, a request is refused if it would place an entry at index 48 or above. No request is granted in the cycle in which the mode changes.
- R8: In half mode, indices wrap from 47 to 0. If the buffer is empty when half mode is entered, the head (and so `alloc_base`) restarts at 0.
- R9: With `downsize`=0 in half mode, full mode returns only once head plus `count` is no more than 48. Until then `half_active` stays 1.
- R10: In full mode, indices wrap from 95 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_req | input | 3 | Number of entries requested this cycle (0 = none) |
| alloc_ok | output | 1 | Request granted this cycle |
| alloc_base | output | 7 | Index of the first entry a grant receives |
| cmpl_vld | input | 1 | Mark one entry complete |
| cmpl_idx | input | 7 | Entry to mark complete |
| commit_cnt | output | 3 | Entries retiring this cycle |
| commit_base | output | 7 | Index of the oldest retiring entry (the head) |
| flush_vld | input | 1 | Branch-recovery flush |
| flush_idx | input | 7 | Youngest entry kept by the flush |
| downsize | input | 1 | Request half capacity |
| half_active | output | 1 | Half capacity in effect |
| full | output | 1 | No free entry at the current capacity |
| empty | output | 1 | No live entry |
| count | output | 7 | Live entries |

## Verification
`alloc_ok`, `alloc_base` and `commit_cnt`/`commit_base` are combinational in the current state and inputs, so they are due in the cycle of the stimulus. The bench samples them at the falling edge of that cycle. `count`, `full`, `empty` and `half_active` are registered and change one rising edge after the event. Completion needs one edge to be recorded before a retirement can report it. A mode change needs one edge of qualification followed by one edge of update. Each check is therefore placed at the falling edge after the edge that is due to produce the result. The retirement monitor compares each reported index, in order, against the queue the driver filled before the completions that release them.

// File: rtl/rob_rs_pkg.sv
// Shared types for the resizable reorder buffer.
package rob_rs_pkg;

    // Capacity currently in effect.
    typedef enum logic {
        CAP_FULL = 1'b0,
        CAP_HALF = 1'b1
    } cap_mode_e;

    // Mode status passed from the size controller to the pointer logic.
    typedef struct packed {
        cap_mode_e mode;      // registered mode
        logic      pend_dn;   // shrink requested, not yet in effect
        logic      go_half;   // mode flips to half on this edge
        logic      switching; // mode flips (either way) on this edge
    } size_ctl_t;

endpackage

// File: rtl/rob_size_ctl.sv
// Capacity mode controller.
// Holds the full/half mode. A shrink takes effect only after no live
// entry sits in the upper partition. A grow takes effect only after the
// live region does not wrap the 48-entry ring.
// Assumes: head < active capacity and count <= active capacity.
module rob_size_ctl
    import rob_rs_pkg::*;
#(
    parameter  int DEPTH = 96,
    localparam int IW    = $clog2(DEPTH),
    localparam int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            downsize,
    input  logic [IW-1:0]   head,
    input  logic [CNTW-1:0] count,
    output size_ctl_t       st,
    output logic [CNTW-1:0] cap_eff
);
    localparam int HALF = DEPTH / 2;
    localparam int SW   = CNTW + 2;

    cap_mode_e      mode_q;
    logic [SW-1:0]  live_end;
    logic           upper_live;
    logic           go_half;
    logic           go_full;

    // End of the live region without wrap, used by both transition tests.
    assign live_end   = SW'(head) + SW'(count);
    // Some live entry lies at index HALF or above (full mode only).
    assign upper_live = (mode_q == CAP_FULL) && (count != '0) &&
                        ((head >= IW'(HALF)) || (live_end > SW'(HALF)));
    assign go_half    = downsize && (mode_q == CAP_FULL) && !upper_live;
    assign go_full    = !downsize && (mode_q == CAP_HALF) && (live_end <= SW'(HALF));

    // Mode register update.
    always_ff @(posedge clk) begin
        if (!rst_n)        mode_q <= CAP_FULL;
        else if (go_half)  mode_q <= CAP_HALF;
        else if (go_full)  mode_q <= CAP_FULL;
    end

    // Status outputs.
    always_comb begin
        st.mode      = mode_q;
        st.pend_dn   = downsize && (mode_q == CAP_FULL);
        st.go_half   = go_half;
        st.switching = go_half || go_full;
        cap_eff      = (mode_q == CAP_HALF) ? CNTW'(HALF) : CNTW'(DEPTH);
    end

    AST_HALF_HEAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == CAP_HALF) |-> (head < IW'(HALF)) && (count <= CNTW'(HALF))); // R8
    AST_SHRINK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_q == CAP_HALF) |-> $past(downsize)); // R7
    AST_GROW_NEEDS_REL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode_q == CAP_HALF) |-> !$past(downsize)); // R9

endmodule

// File: rtl/rob_ptr_ctl.sv
// Head pointer and occupancy counter.
// Grants reservations whole, applies retirements and flushes, and wraps
// indices at the capacity in effect. The tail is derived as head+count.
// Assumes: flush_idx names a live entry; commit_n is 0 during a flush.
module rob_ptr_ctl
    import rob_rs_pkg::*;
#(
    parameter  int DEPTH = 96,
    parameter  int WIDTH = 4,
    localparam int IW    = $clog2(DEPTH),
    localparam int CNTW  = $clog2(DEPTH + 1),
    localparam int CW    = $clog2(WIDTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CW-1:0]   alloc_req,
    input  logic            flush_vld,
    input  logic [IW-1:0]   flush_idx,
    input  logic [CW-1:0]   commit_n,
    input  size_ctl_t       st,
    input  logic [CNTW-1:0] cap_eff,
    output logic [IW-1:0]   head_q,
    output logic [CNTW-1:0] count_q,
    output logic [IW-1:0]   tail,
    output logic            alloc_fire
);
    localparam int HALF = DEPTH / 2;
    localparam int SW   = CNTW + 2;

    // Wrap a sum known to be below twice the capacity.
    function automatic logic [IW-1:0] wrap_at(input logic [SW-1:0] s, input logic [SW-1:0] cap);
        if (s >= cap) return IW'(s - cap);
        return IW'(s);
    endfunction

    logic [SW-1:0]   cap_w;
    logic [SW-1:0]   free_w;
    logic [SW-1:0]   fl_span;
    logic            room_ok;
    logic [IW-1:0]   head_n;
    logic [CNTW-1:0] count_n;

    assign cap_w  = SW'(cap_eff);
    assign tail   = wrap_at(SW'(head_q) + SW'(count_q), cap_w);
    assign free_w = cap_w - SW'(count_q);

    // While a shrink is pending, no granted entry may reach the upper half.
    assign room_ok = !st.pend_dn || ((SW'(tail) + SW'(alloc_req)) <= SW'(HALF));

    // Whole-request grant decision.
    assign alloc_fire = !flush_vld && !st.switching && (alloc_req != '0) &&
                        (alloc_req <= CW'(WIDTH)) && (SW'(alloc_req) <= free_w) && room_ok;

    // Distance from head to the kept flush entry, modulo capacity.
    assign fl_span = (flush_idx >= head_q) ? (SW'(flush_idx) - SW'(head_q))
                                           : (SW'(flush_idx) + cap_w - SW'(head_q));

    // Next head and occupancy.
    always_comb begin
        if (flush_vld) begin
            head_n  = head_q;
            count_n = CNTW'(fl_span + SW'(1));
        end else begin
            head_n  = wrap_at(SW'(head_q) + SW'(commit_n), cap_w);
            count_n = CNTW'(SW'(count_q) + (alloc_fire ? SW'(alloc_req) : SW'(0)) - SW'(commit_n));
        end
        if (st.go_half && (count_n == '0)) head_n = '0;
    end

    // Pointer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            count_q <= '0;
        end else begin
            head_q  <= head_n;
            count_q <= count_n;
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= cap_eff); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_fire |=> (count_q <= cap_eff)); // R2
    AST_FLUSH_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_vld |=> (count_q <= $past(count_q)) && (head_q == $past(head_q))); // R5
    AST_HALF_TAIL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st.mode == CAP_HALF) |-> (tail < IW'(HALF))); // R8

endmodule

// File: rtl/rob_done_vec.sv
// Completion flags and in-order retirement scan.
// One flag per entry: set by a completion, cleared when the entry is
// granted again. Retirement counts the unbroken run of set flags from the
// head, limited by the port width and the occupancy.
// Assumes: completions target live entries only.
module rob_done_vec #(
    parameter  int DEPTH = 96,
    parameter  int WIDTH = 4,
    localparam int IW    = $clog2(DEPTH),
    localparam int CNTW  = $clog2(DEPTH + 1),
    localparam int CW    = $clog2(WIDTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IW-1:0]   head,
    input  logic [IW-1:0]   tail,
    input  logic [CNTW-1:0] count,
    input  logic [CNTW-1:0] cap_eff,
    input  logic            alloc_fire,
    input  logic [CW-1:0]   alloc_req,
    input  logic            cmpl_vld,
    input  logic [IW-1:0]   cmpl_idx,
    input  logic            flush_vld,
    output logic [CW-1:0]   commit_n
);
    localparam int SW = CNTW + 2;

    // Wrap a sum known to be below twice the capacity.
    function automatic logic [IW-1:0] wrap_at(input logic [SW-1:0] s, input logic [SW-1:0] cap);
        if (s >= cap) return IW'(s - cap);
        return IW'(s);
    endfunction

    logic [DEPTH-1:0] done_q;
    logic [DEPTH-1:0] clr_vec;
    logic [IW-1:0]    slot_idx [WIDTH];
    logic [IW-1:0]    scan_idx [WIDTH];

    for (genvar k = 0; k < WIDTH; k++) begin : g_lane
        assign slot_idx[k] = wrap_at(SW'(tail) + SW'(k), SW'(cap_eff));
        assign scan_idx[k] = wrap_at(SW'(head) + SW'(k), SW'(cap_eff));
    end

    // Entries being granted this cycle lose their completion flag.
    always_comb begin
        clr_vec = '0;
        for (int k = 0; k < WIDTH; k++) begin
            if (alloc_fire && (CW'(k) < alloc_req)) clr_vec[slot_idx[k]] = 1'b1;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_flag
        // Per-entry completion flag.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 done_q[i] <= 1'b0;
            else if (clr_vec[i])                        done_q[i] <= 1'b0;
            else if (cmpl_vld && (cmpl_idx == IW'(i)))  done_q[i] <= 1'b1;
        end
    end

    // Unbroken run of complete entries from the head.
    always_comb begin
        logic run;
        run      = !flush_vld;
        commit_n = '0;
        for (int k = 0; k < WIDTH; k++) begin
            if (run && (CNTW'(k) < count) && done_q[scan_idx[k]]) commit_n = commit_n + CW'(1);
            else                                                  run      = 1'b0;
        end
    end

    AST_COMMIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        CNTW'(commit_n) <= count); // R3
    AST_FRESH_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_fire |=> !done_q[$past(tail)]); // R4

endmodule

// File: rtl/rob_resizable.sv
// Resizable reorder buffer top.
// Ring of DEPTH entries with WIDTH-wide grant and retire ports, a flush
// that keeps entries up to a named index, and a capacity that can be
// halved at runtime once the upper partition is vacated.
// Assumes: the requester respects alloc_ok; flush and completion indices
// name live entries.
module rob_resizable
    import rob_rs_pkg::*;
#(
    parameter  int DEPTH = 96,
    parameter  int WIDTH = 4,
    localparam int IW    = $clog2(DEPTH),
    localparam int CNTW  = $clog2(DEPTH + 1),
    localparam int CW    = $clog2(WIDTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CW-1:0]   alloc_req,
    output logic            alloc_ok,
    output logic [IW-1:0]   alloc_base,
    input  logic            cmpl_vld,
    input  logic [IW-1:0]   cmpl_idx,
    output logic [CW-1:0]   commit_cnt,
    output logic [IW-1:0]   commit_base,
    input  logic            flush_vld,
    input  logic [IW-1:0]   flush_idx,
    input  logic            downsize,
    output logic            half_active,
    output logic            full,
    output logic            empty,
    output logic [CNTW-1:0] count
);
    size_ctl_t       st;
    logic [CNTW-1:0] cap_eff;
    logic [IW-1:0]   head_q;
    logic [IW-1:0]   tail;
    logic [CNTW-1:0] count_q;
    logic [CW-1:0]   commit_n;
    logic            alloc_fire;

    rob_size_ctl #(.DEPTH(DEPTH)) u_size (
        .clk      (clk),
        .rst_n    (rst_n),
        .downsize (downsize),
        .head     (head_q),
        .count    (count_q),
        .st       (st),
        .cap_eff  (cap_eff)
    );

    rob_ptr_ctl #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_req  (alloc_req),
        .flush_vld  (flush_vld),
        .flush_idx  (flush_idx),
        .commit_n   (commit_n),
        .st         (st),
        .cap_eff    (cap_eff),
        .head_q     (head_q),
        .count_q    (count_q),
        .tail       (tail),
        .alloc_fire (alloc_fire)
    );

    rob_done_vec #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_done (
        .clk        (clk),
        .rst_n      (rst_n),
        .head       (head_q),
        .tail       (tail),
        .count      (count_q),
        .cap_eff    (cap_eff),
        .alloc_fire (alloc_fire),
        .alloc_req  (alloc_req),
        .cmpl_vld   (cmpl_vld),
        .cmpl_idx   (cmpl_idx),
        .flush_vld  (flush_vld),
        .commit_n   (commit_n)
    );

    // Output mapping.
    always_comb begin
        alloc_ok    = alloc_fire;
        alloc_base  = tail;
        commit_cnt  = commit_n;
        commit_base = head_q;
        half_active = (st.mode == CAP_HALF);
        full        = (count_q == cap_eff);
        empty       = (count_q == '0);
        count       = count_q;
    end

    AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !alloc_ok); // R6
    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        flush_vld |-> !alloc_ok && (commit_cnt == '0)); // R5

endmodule

// File: tb/sim_rob_resizable.sv
module sim_rob_resizable;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] alloc_req = '0;
    logic       alloc_ok;
    logic [6:0] alloc_base;
    logic       cmpl_vld = 1'b0;
    logic [6:0] cmpl_idx = '0;
    logic [2:0] commit_cnt;
    logic [6:0] commit_base;
    logic       flush_vld = 1'b0;
    logic [6:0] flush_idx = '0;
    logic       downsize = 1'b0;
    logic       half_active;
    logic       full;
    logic       empty;
    logic [6:0] count;

    int n_chk = 0;
    int n_bad = 0;
    int exp_q[$];

    rob_resizable #(.DEPTH(96), .WIDTH(4)) u0 (
        .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_ok(alloc_ok),
        .alloc_base(alloc_base), .cmpl_vld(cmpl_vld), .cmpl_idx(cmpl_idx),
        .commit_cnt(commit_cnt), .commit_base(commit_base), .flush_vld(flush_vld),
        .flush_idx(flush_idx), .downsize(downsize), .half_active(half_active),
        .full(full), .empty(empty), .count(count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check_eq(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    // Check registered state at the falling edge, return after the next rise.
    task automatic see(string tag, int cnt, int fl, int em, int hf, int base);
        @(negedge clk);
        check_eq(tag, "count", int'(count), cnt);
        check_eq(tag, "full", int'(full), fl);
        check_eq(tag, "empty", int'(empty), em);
        check_eq(tag, "half_active", int'(half_active), hf);
        if (base >= 0) check_eq(tag, "alloc_base", int'(alloc_base), base);
        step();
    endtask

    task automatic do_alloc(int n, int ok, int base, string tag);
        alloc_req = 3'(n);
        @(negedge clk);
        check_eq(tag, "alloc_ok", int'(alloc_ok), ok);
        check_eq(tag, "alloc_base", int'(alloc_base), base);
        step();
        alloc_req = '0;
    endtask

    task automatic do_cmpl(int idx);
        cmpl_vld = 1'b1;
        cmpl_idx = 7'(idx);
        step();
        cmpl_vld = 1'b0;
    endtask

    task automatic do_flush(int idx);
        flush_vld = 1'b1;
        flush_idx = 7'(idx);
        alloc_req = 3'd1;
        @(negedge clk);
        check_eq("R5", "alloc_ok during flush", int'(alloc_ok), 0);
        check_eq("R5", "commit_cnt during flush", int'(commit_cnt), 0);
        step();
        flush_vld = 1'b0;
        alloc_req = '0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // Monitor: pops expected retirements in order as they are reported.
    always @(negedge clk) begin
        if (rst_n && commit_cnt != 0) begin
            int cap;
            cap = half_active ? 48 : 96;
            for (int i = 0; i < int'(commit_cnt); i++) begin
                int pos;
                pos = int'(commit_base) + i;
                if (pos >= cap) pos -= cap;
                if (exp_q.size() == 0) check_eq("R3", "unexpected retirement", pos, -1);
                else check_eq("R3", "retired index", pos, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        check_eq("R1", "empty in reset", int'(empty), 1);
        check_eq("R1", "count in reset", int'(count), 0);
        step();
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", "commit_cnt", int'(commit_cnt), 0);
        step();
        see("R1", 0, 0, 1, 0, 0);

        // R2: two grants.
        do_alloc(4, 1, 0, "R2");
        do_alloc(3, 1, 4, "R2");
        see("R2", 7, 0, 0, 0, 7);

        // R3: out-of-order completion does not retire past the head.
        do_cmpl(1);
        @(negedge clk);
        check_eq("R3", "blocked by incomplete head", int'(commit_cnt), 0);
        step();
        // R4: same-cycle completion not yet visible.
        exp_q.push_back(0); exp_q.push_back(1);
        cmpl_vld = 1'b1; cmpl_idx = 7'd0;
        @(negedge clk);
        check_eq("R4", "completion not visible same cycle", int'(commit_cnt), 0);
        step();
        cmpl_vld = 1'b0;
        @(negedge clk);
        check_eq("R3", "two retire", int'(commit_cnt), 2);
        step();
        see("R3", 5, 0, 0, 0, 7);

        // R3: width cap of four per cycle.
        do_cmpl(6); do_cmpl(5); do_cmpl(4); do_cmpl(3);
        for (int i = 2; i <= 6; i++) exp_q.push_back(i);
        do_cmpl(2);
        @(negedge clk);
        check_eq("R3", "retire capped at 4", int'(commit_cnt), 4);
        step();
        step();
        see("R3", 0, 0, 1, 0, 7);

        // R6, R10: fill to 96 with wrap past 95.
        for (int k = 0; k < 24; k++) do_alloc(4, 1, (7 + 4*k) % 96, "R10");
        see("R6", 96, 1, 0, 0, 7);
        do_alloc(1, 0, 7, "R2");
        see("R2", 96, 1, 0, 0, 7);

        // R5: flush keeps 7..10.
        do_flush(10);
        see("R5", 4, 0, 0, 0, 11);

        // R7: occupy the upper half, then request shrink.
        for (int k = 0; k < 10; k++) do_alloc(4, 1, 11 + 4*k, "R2");
        do_alloc(1, 1, 51, "R2");
        downsize = 1'b1;
        see("R7", 45, 0, 0, 0, 52);
        do_alloc(1, 0, 52, "R7");
        see("R7", 45, 0, 0, 0, 52);
        do_flush(45);
        // Mode changes on this edge: no grant.
        alloc_req = 3'd2;
        @(negedge clk);
        check_eq("R7", "half before switch edge", int'(half_active), 0);
        check_eq("R7", "no grant in switching cycle", int'(alloc_ok), 0);
        step();
        alloc_req = '0;
        see("R7", 39, 0, 0, 1, 46);

        // R8, R6: half-mode wrap and half-capacity full.
        do_alloc(2, 1, 46, "R8");
        do_alloc(4, 1, 0, "R8");
        do_alloc(3, 1, 4, "R8");
        see("R6", 48, 1, 0, 1, 7);
        do_alloc(1, 0, 7, "R6");
        do_flush(2);
        see("R5", 44, 0, 0, 1, 3);

        // R9: grow waits while the live region wraps.
        downsize = 1'b0;
        step(); step();
        see("R9", 44, 0, 0, 1, 3);
        for (int i = 47; i >= 8; i--) do_cmpl(i);
        do_cmpl(0);
        do_cmpl(1);
        check_eq("R9", "half held while wrapped", int'(half_active), 1);
        for (int i = 7; i <= 47; i++) exp_q.push_back(i);
        exp_q.push_back(0); exp_q.push_back(1);
        do_cmpl(7);
        repeat (14) step();
        see("R9", 1, 0, 0, 0, 3);
        exp_q.push_back(2);
        do_cmpl(2);
        step();
        see("R3", 0, 0, 1, 0, 3);

        // R8: empty with head in the upper half, then shrink restarts at 0.
        for (int k = 0; k < 12; k++) do_alloc(4, 1, 3 + 4*k, "R2");
        for (int i = 3; i <= 50; i++) exp_q.push_back(i);
        for (int i = 3; i <= 50; i++) do_cmpl(i);
        step();
        see("R3", 0, 0, 1, 0, 51);
        downsize = 1'b1;
        step();
        see("R8", 0, 0, 1, 1, 0);
        do_alloc(1, 1, 0, "R8");
        step();
        check_eq("R3", "pending retirements left", exp_q.size(), 0);

        summary();
        $finish;
    end
endmodule